// File: doc/BRIEF.md
# Multi-Channel Coincidence Trigger

This block watches a wide bank of single-bit pulse inputs and fires a trigger whenever two or more distinct channels become active inside one coincidence window. Each input first crosses into the sample clock domain through a short synchroniser chain. A rising-edge detector then turns it into a one-clock event. That event stretches into a per-channel activity flag that stays set for a programmable number of clocks.

A layered reduction tree halves the number of nodes at each stage. Each node carries two results: whether any flag below it is set, and whether at least two are set. Once the at-least-two result is set at a node, it stays set at every node above it. The trigger is a registered one-cycle pulse. After it fires, a holdoff counter keeps the trigger quiet so that one physical event cannot fire twice. A separate output reports intervals in which exactly one channel is active, so that later logic can filter lone hits in software.

The sample clock must be several times faster than the narrowest input pulse, which is about 20 ns. With a 200 MHz clock and the default window of four clocks, the window spans 20 ns.

Top module: `coinc_trigger`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `trig_o` and `single_o` are 0. Reset also clears every activity flag, every synchroniser stage and the holdoff counter.
- R2: Suppose a lone channel rises and is first sampled at clock edge E0. Then `single_o` goes high after edge E0+3 and stays high for exactly WINDOW cycles, and `trig_o` stays 0.
- R3: Suppose two distinct channels are first sampled high at E0 and at E0+d, with d < WINDOW. Then `trig_o` pulses exactly once, after edge E0+3+d.
- R4: Two distinct channels whose first samples are WINDOW or more cycles apart produce no trigger, and `single_o` is then high for 2·WINDOW cycles in total.
- R5: A second rising edge on the same channel never triggers. It restarts that channel's window, so `single_o` stays high for WINDOW+d cycles when the two rises are d < WINDOW cycles apart.
- R6: Every trigger pulse on `trig_o` lasts exactly one clock.
- R7: For HOLDOFF cycles after a trigger pulse, no further trigger fires. A coincidence that begins and ends inside that interval is dropped. A coincidence that arrives after the holdoff has ended fires normally.
- R8: An input that is held high produces a single event: `single_o` is high for only WINDOW cycles.
- R9: Any channel index, including channel 0 and channel NUM_CH-1, can take part in a trigger. Three channels that coincide produce one trigger pulse.
- R10: `single_o` is 0 during any cycle whose preceding cycle had two or more active flags. When two channels are first sampled at the same edge, `single_o` never rises.
- R11: A reset pulse in the middle of a window discards the pending flags. A channel that rises after the reset does not combine with a channel that rose before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_i | input | NUM_CH | Asynchronous pulse inputs, one per channel |
| trig_o | output | 1 | One-cycle pulse when two or more channels coincide |
| single_o | output | 1 | High while exactly one channel flag was active in the previous cycle |

## Verification
A channel that is first sampled at edge E0 sets its flag after E0+2. That adds two synchroniser flops and the edge register. The registered trigger or single-hit output then appears after E0+3. A second channel sampled d cycles later pushes the trigger to E0+3+d.

The bench drives inputs on the falling edge and samples one time unit after each rising edge. It numbers the iterations from the edge that first samples a stimulus. It compares the iteration of the first trigger against 3+d, and it compares the number of single-hit cycles against a closed form in WINDOW and d. It also counts trigger pulses across a whole run, so that a repeat firing during holdoff would be caught.

// File: rtl/ct_pkg.sv
package ct_pkg;

   typedef struct packed {
      logic any;
      logic multi;
   } ct_node_t;

   // number of nodes at tree level lvl for n leaves (ceiling halving)
   function automatic int ct_width(input int n, input int lvl);
      return (n + (1 << lvl) - 1) >> lvl;
   endfunction

   function automatic ct_node_t ct_merge(input ct_node_t a, input ct_node_t b);
      ct_node_t r;
      r.any   = a.any | b.any;
      r.multi = a.multi | b.multi | (a.any & b.any);
      return r;
   endfunction

endpackage

// File: rtl/ct_chan_front.sv
module ct_chan_front #(
   parameter int SYNC_STAGES = 2,
   parameter int WINDOW      = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic pulse_i,
   output logic active_o
);
   localparam int CW = $clog2(WINDOW + 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;
   logic [CW-1:0]          cnt_q;
   logic                   rise;

   assign rise     = sync_q[SYNC_STAGES-1] & ~last_q;
   assign active_o = (cnt_q != '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         sync_q <= '0;
         last_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pulse_i};
         last_q <= sync_q[SYNC_STAGES-1];
         if (rise)
            cnt_q <= CW'(WINDOW);
         else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
      end
   end

   // R2: an edge event always opens the window on the next cycle
   p_rise_sets_flag_r2: assert property (@(posedge clk) disable iff (rst)
      rise |=> active_o);

   // R8: edge events are never back to back, so a held level counts once
   p_single_event_r8: assert property (@(posedge clk) disable iff (rst)
      rise |=> !rise);

endmodule

// File: rtl/ct_pair_tree.sv
module ct_pair_tree
   import ct_pkg::*;
#(
   parameter int NUM_CH = 100
) (
   input  logic [NUM_CH-1:0] flags_i,
   output logic              any_o,
   output logic              multi_o
);
   localparam int LEVELS = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   ct_node_t lvl [LEVELS+1][NUM_CH];

   for (genvar i = 0; i < NUM_CH; i++) begin : g_leaf
      assign lvl[0][i] = '{any: flags_i[i], multi: 1'b0};
   end

   for (genvar l = 0; l < LEVELS; l++) begin : g_level
      for (genvar i = 0; i < NUM_CH; i++) begin : g_node
         if (i >= ct_width(NUM_CH, l + 1)) begin : g_unused
            assign lvl[l+1][i] = '0;
         end else if (2 * i + 1 < ct_width(NUM_CH, l)) begin : g_pair
            assign lvl[l+1][i] = ct_merge(lvl[l][2*i], lvl[l][2*i+1]);
         end else begin : g_pass
            assign lvl[l+1][i] = lvl[l][2*i];
         end
      end
   end

   assign any_o   = lvl[LEVELS][0].any;
   assign multi_o = lvl[LEVELS][0].multi;

endmodule

// File: rtl/ct_fire_ctl.sv
module ct_fire_ctl #(
   parameter int HOLDOFF       = 16,
   parameter bit REPORT_SINGLE = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic any_i,
   input  logic multi_i,
   output logic trig_o,
   output logic single_o
);
   localparam int HW = $clog2(HOLDOFF + 1);

   logic [HW-1:0] hold_q;
   logic          fire;

   assign fire = multi_i && (hold_q == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         trig_o <= 1'b0;
         hold_q <= '0;
      end else begin
         trig_o <= fire;
         if (fire)
            hold_q <= HW'(HOLDOFF);
         else if (hold_q != '0)
            hold_q <= hold_q - 1'b1;
      end
   end

   if (REPORT_SINGLE) begin : g_single
      always_ff @(posedge clk) begin
         if (rst) single_o <= 1'b0;
         else     single_o <= any_i & ~multi_i;
      end
   end else begin : g_no_single
      assign single_o = 1'b0;
   end

   // R6: trigger is one clock wide
   p_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
      trig_o |=> !trig_o);

   // R7: a running holdoff blocks the next trigger
   p_holdoff_r7: assert property (@(posedge clk) disable iff (rst)
      (hold_q != '0) |=> !trig_o);

endmodule

// File: rtl/coinc_trigger.sv
module coinc_trigger #(
   parameter int NUM_CH        = 100,
   parameter int SYNC_STAGES   = 2,
   parameter int WINDOW        = 4,
   parameter int HOLDOFF       = 16,
   parameter bit REPORT_SINGLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NUM_CH-1:0] pulse_i,
   output logic              trig_o,
   output logic              single_o
);
   if (NUM_CH < 2)          begin : g_chk_ch   $error("NUM_CH must be at least 2"); end
   if (SYNC_STAGES < 2)     begin : g_chk_sync $error("SYNC_STAGES must be at least 2"); end
   if (WINDOW < 1)          begin : g_chk_win  $error("WINDOW must be at least 1"); end
   if (HOLDOFF < WINDOW)    begin : g_chk_hold $error("HOLDOFF must cover WINDOW"); end

   logic [NUM_CH-1:0] flags;
   logic              any_act;
   logic              multi_act;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      ct_chan_front #(
         .SYNC_STAGES (SYNC_STAGES),
         .WINDOW      (WINDOW)
      ) u_front (
         .clk      (clk),
         .rst      (rst),
         .pulse_i  (pulse_i[c]),
         .active_o (flags[c])
      );
   end

   ct_pair_tree #(
      .NUM_CH (NUM_CH)
   ) u_tree (
      .flags_i (flags),
      .any_o   (any_act),
      .multi_o (multi_act)
   );

   ct_fire_ctl #(
      .HOLDOFF       (HOLDOFF),
      .REPORT_SINGLE (REPORT_SINGLE)
   ) u_ctl (
      .clk      (clk),
      .rst      (rst),
      .any_i    (any_act),
      .multi_i  (multi_act),
      .trig_o   (trig_o),
      .single_o (single_o)
   );

   // R3: tree's at-least-two result matches a population count of the flags
   p_tree_count_r3: assert property (@(posedge clk) disable iff (rst)
      multi_act == ($countones(flags) >= 2));

   // R2: tree's any result matches the flag bank
   p_tree_any_r2: assert property (@(posedge clk) disable iff (rst)
      any_act == (flags != '0));

   // R3: every trigger follows a cycle with a coincidence
   p_trig_cause_r3: assert property (@(posedge clk) disable iff (rst)
      trig_o |-> $past(multi_act));

   // R10: single-hit report never coincides with a trigger
   p_excl_r10: assert property (@(posedge clk) disable iff (rst)
      !(trig_o && single_o));

endmodule

// File: tb/coinc_trigger_test.sv
module coinc_trigger_test;
   localparam int NUM_CH  = 100;
   localparam int WINDOW  = 4;
   localparam int HOLDOFF = 16;
   localparam int RUN     = 40;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [NUM_CH-1:0] pulse = '0;
   logic              trig;
   logic              single;

   always #2.5 clk = ~clk;

   coinc_trigger #(
      .NUM_CH  (NUM_CH),
      .WINDOW  (WINDOW),
      .HOLDOFF (HOLDOFF)
   ) uut (
      .clk      (clk),
      .rst      (rst),
      .pulse_i  (pulse),
      .trig_o   (trig),
      .single_o (single)
   );

   int checks = 0;
   int errors = 0;
   int it, trig_n, trig_first, single_n;
   bit done = 1'b0;

   // channel a, channel b, delay of b after a
   localparam logic [17:0] VEC [7] = '{
      {7'd0,  7'd1,  4'd0},
      {7'd5,  7'd99, 4'd1},
      {7'd10, 7'd20, 4'd3},
      {7'd30, 7'd31, 4'd4},
      {7'd40, 7'd40, 4'd2},
      {7'd50, 7'd60, 4'd6},
      {7'd99, 7'd0,  4'd2}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_stats();
      it = 0; trig_n = 0; trig_first = -1; single_n = 0;
   endtask

   // drive v before edge number it, sample after it
   task automatic step(input logic [NUM_CH-1:0] v);
      @(negedge clk);
      pulse = v;
      @(posedge clk);
      #1;
      if (trig) begin
         if (trig_first < 0) trig_first = it;
         trig_n++;
      end
      if (single) single_n++;
      it++;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      pulse = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (2) @(posedge clk);
      #1;
      chk(trig == 1'b0 && single == 1'b0, "R1 during reset", {trig, single}, 0);
      do_reset();
      clear_stats();
      step('0);
      chk(trig == 1'b0 && single == 1'b0, "R1 after release", {trig, single}, 0);

      // table of pair patterns: R3 R4 R5 R9 R10
      foreach (VEC[k]) begin
         int a, b, d, exp_first, exp_single;
         a = int'(VEC[k][17:11]);
         b = int'(VEC[k][10:4]);
         d = int'(VEC[k][3:0]);
         if (a != b && d < WINDOW) begin
            exp_first = 3 + d; exp_single = 2 * d;
         end else begin
            exp_first = -1;
            exp_single = (a == b && d < WINDOW) ? WINDOW + d : 2 * WINDOW;
         end
         clear_stats();
         for (int t = 0; t < RUN; t++) begin
            logic [NUM_CH-1:0] v;
            v = '0;
            if (t == 0) v[a] = 1'b1;
            if (t == d) v[b] = 1'b1;
            step(v);
         end
         chk(trig_first == exp_first, "R3/R4/R5 trigger cycle", trig_first, exp_first);
         chk(trig_n == ((exp_first >= 0) ? 1 : 0), "R3/R6 trigger count", trig_n,
             (exp_first >= 0) ? 1 : 0);
         chk(single_n == exp_single, "R2/R10 single-hit cycles", single_n, exp_single);
      end

      // R2: lone channel
      clear_stats();
      for (int t = 0; t < RUN; t++) step((t == 0) ? 100'd1 << 17 : '0);
      chk(trig_n == 0, "R2 lone no trigger", trig_n, 0);
      chk(single_n == WINDOW, "R2 lone single width", single_n, WINDOW);

      // R8: held level counts once
      clear_stats();
      for (int t = 0; t < RUN; t++) step((t < 20) ? 100'd1 << 7 : '0);
      chk(single_n == WINDOW, "R8 held level single width", single_n, WINDOW);
      chk(trig_n == 0, "R8 held level no trigger", trig_n, 0);

      // R9: three channels at once incl. both ends
      clear_stats();
      for (int t = 0; t < RUN; t++) begin
         logic [NUM_CH-1:0] v;
         v = '0;
         if (t == 0) begin v[0] = 1'b1; v[50] = 1'b1; v[99] = 1'b1; end
         step(v);
      end
      chk(trig_n == 1 && trig_first == 3, "R9 three channels", trig_first, 3);

      // R7: holdoff drops a coincidence inside it, later one fires
      clear_stats();
      for (int t = 0; t < RUN; t++) begin
         logic [NUM_CH-1:0] v;
         v = '0;
         if (t == 0)  begin v[2] = 1'b1; v[3] = 1'b1; end
         if (t == 5)  begin v[4] = 1'b1; v[5] = 1'b1; end
         if (t == 25) begin v[6] = 1'b1; v[7] = 1'b1; end
         step(v);
      end
      chk(trig_n == 2, "R7 trigger count with holdoff", trig_n, 2);
      chk(trig_first == 3, "R7 first trigger cycle", trig_first, 3);

      // R11: reset mid-window discards pending flags
      clear_stats();
      step(100'd1 << 3);
      step('0);
      step('0);
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk(single == 1'b0 && trig == 1'b0, "R11 outputs cleared", {trig, single}, 0);
      clear_stats();
      for (int t = 0; t < RUN; t++) step((t == 0) ? 100'd1 << 4 : '0);
      chk(trig_n == 0, "R11 no trigger across reset", trig_n, 0);
      chk(single_n == WINDOW, "R11 new channel alone", single_n, WINDOW);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule